// File: doc/BRIEF.md
# Zero-suppressed token readout serializer

The block empties a front-end chip's event store onto one data line that several chips share. It stays silent until a one-cycle readout token arrives. It then sends 16-bit words, one bit per clock and most significant bit first. The first word is the chip identity word. Channels follow in ascending order, and only those with at least one stored event are sent. Each channel gives one header word, followed by its event words in storage order. When the last bit is out, the block pulses its token output so that the next chip on the line can start.

Each word carries a type flag in its top bit and an even-parity bit in bit 0. The event memory supplies one entry per clock through an address port: a channel number and an event index. The entry comes back combinationally, in the same cycle. A configuration input decides what a chip with no stored events does when it gets the token. It either passes the token on at once, or it first sends its identity word alone.

Top module: `zs_readout_ser`

## Requirements
- R1: After reset, dout_en_o, dout_o and token_o are 0.
- R2: When token_i is sampled high while the block is idle and a transmission is due, dout_en_o rises in the next cycle. The first word sent is the identity word: bits15:8 = chip_id_i, bits7:1 = 0, bit0 = parity.
- R3: Words are sent back to back, one bit per clock, most significant bit first. dout_en_o stays high, with no gap, from the first bit to the last bit.
- R4: A channel header word is: bit15 = 1, bits14:9 = channel number, bits8:5 = event count (1 to 8, taken from hit_cnt_i[4*ch +: 4]), bits4:1 = 0, bit0 = parity.
- R5: Each header is followed by exactly count event words, for event indices 0 up to count-1 in that order. The block reads each entry through ev_ch_o and ev_idx_o. ev_data_i carries {bcid[11:0], disc[1:0]}. An event word is: bit15 = 0, bits14:3 = bcid, bits2:1 = disc, bit0 = parity.
- R6: Bit0 of every word is the XOR of bits15:1, so each word has an even number of ones.
- R7: Channels whose count is 0 are skipped. Headers appear in strictly ascending channel order.
- R8: If every count is 0 and arcid_i = 0, nothing is sent. token_o is high in the cycle right after the cycle in which token_i was sampled.
- R9: If every count is 0 and arcid_i = 1, only the identity word is sent.
- R10: token_o is high for exactly one cycle, in the cycle right after the last bit. dout_en_o is 0 while token_o is high.
- R11: A token_i pulse that arrives during a transmission has no effect. The stream is unchanged and token_o pulses only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_id_i | input | 8 | Identity sent in the first word |
| arcid_i | input | 1 | 1: send the identity word even when no events are stored |
| token_i | input | 1 | Readout token from the previous chip (one-cycle pulse) |
| hit_cnt_i | input | 256 | Event count per channel, 4 bits each; channel c is at [4c +: 4] |
| ev_ch_o | output | 6 | Event memory address: channel |
| ev_idx_o | output | 3 | Event memory address: event index |
| ev_data_i | input | 14 | Event entry {bcid, disc}, returned in the same cycle |
| dout_o | output | 1 | Serial data |
| dout_en_o | output | 1 | High while the block drives the shared line |
| token_o | output | 1 | Token to the next chip |

## Verification
Some properties are checked on every cycle. Every loaded word has even parity. Each header belongs to a non-empty channel and has a higher channel number than the header before it. The event index stays below the channel's count. The token output is a single-cycle pulse and never coincides with line drive. A token arriving mid-stream never restarts or stops the transmission. Only the bench scenarios can show the rest: the exact bit order, the field contents, the word count of sparse and fully loaded stores, gap-free line drive, the token timing, and the two empty-store behaviours.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int WORD_W = 16;
  localparam int CH_W   = 6;
  localparam int NUM_CH = 1 << CH_W;
  localparam int CNT_W  = 4;
  localparam int IDX_W  = 3;
  localparam int BCID_W = 12;
  localparam int DISC_W = 2;
  localparam int ID_W   = 8;
  localparam int EV_W   = BCID_W + DISC_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {K_ID, K_HDR, K_EV} kind_e;

  function automatic word_t seal(input word_t w);
    word_t r;
    r    = w;
    r[0] = ^w[WORD_W-1:1];
    return r;
  endfunction

  function automatic word_t make_id(input logic [ID_W-1:0] id);
    return seal({id, {(WORD_W-ID_W){1'b0}}});
  endfunction

  function automatic word_t make_hdr(input logic [CH_W-1:0] ch, input logic [CNT_W-1:0] n);
    return seal({1'b1, ch, n, {(WORD_W-1-CH_W-CNT_W){1'b0}}});
  endfunction

  function automatic word_t make_ev(input logic [EV_W-1:0] e);
    return seal({1'b0, e, 1'b0});
  endfunction
endpackage

// File: rtl/zs_scan.sv
module zs_scan #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0] mask_i,
  input  logic [IW:0]  start_i,
  output logic         found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit at or above start_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i] && ((IW+1)'(i) >= start_i)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/zs_shift.sv
module zs_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         bit_o,
  output logic         last_o
);
  localparam int BW = $clog2(W);
  logic [W-1:0]  sh_q;
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= BW'(W - 1);
    end else if (shift_i) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o  = sh_q[W-1];
  assign last_o = (cnt_q == '0);

  p_parity_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (^word_i == 1'b0));
endmodule

// File: rtl/zs_readout_ser.sv
module zs_readout_ser
  import zs_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ID_W-1:0]         chip_id_i,
  input  logic                    arcid_i,
  input  logic                    token_i,
  input  logic [NUM_CH*CNT_W-1:0] hit_cnt_i,
  output logic [CH_W-1:0]         ev_ch_o,
  output logic [IDX_W-1:0]        ev_idx_o,
  input  logic [EV_W-1:0]         ev_data_i,
  output logic                    dout_o,
  output logic                    dout_en_o,
  output logic                    token_o
);
  logic [NUM_CH-1:0] nonempty;
  logic              busy_q, token_q;
  kind_e             kind_q;
  logic [CH_W-1:0]   cur_ch_q;
  logic [IDX_W-1:0]  ev_idx_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ne
    assign nonempty[c] = |hit_cnt_i[c*CNT_W +: CNT_W];
  end

  logic [CNT_W-1:0] cnt_cur, cnt_found;
  logic [CH_W:0]    scan_start;
  logic             found;
  logic [CH_W-1:0]  found_idx;
  logic             more_ev, step_ev, have_next, start_send, last_bit, sh_bit, load;
  logic [IDX_W-1:0] nxt_idx;
  word_t            next_word, load_word;

  zs_scan #(.N(NUM_CH), .IW(CH_W)) u_scan (
    .mask_i (nonempty),
    .start_i(scan_start),
    .found_o(found),
    .idx_o  (found_idx)
  );

  assign cnt_cur    = hit_cnt_i[int'(cur_ch_q)*CNT_W +: CNT_W];
  assign cnt_found  = hit_cnt_i[int'(found_idx)*CNT_W +: CNT_W];
  assign scan_start = (kind_q == K_ID) ? '0 : ({1'b0, cur_ch_q} + 1'b1);
  assign more_ev    = (kind_q == K_EV) && ((CNT_W'(ev_idx_q) + 1'b1) < cnt_cur);
  assign step_ev    = (kind_q == K_HDR) || more_ev;
  assign have_next  = step_ev || found;
  assign nxt_idx    = (kind_q == K_HDR) ? '0 : ev_idx_q + 1'b1;
  assign next_word  = step_ev ? make_ev(ev_data_i) : make_hdr(found_idx, cnt_found);
  assign start_send = !busy_q && token_i && ((|nonempty) || arcid_i);
  assign load       = start_send || (busy_q && last_bit && have_next);
  assign load_word  = busy_q ? next_word : make_id(chip_id_i);

  assign ev_ch_o  = cur_ch_q;
  assign ev_idx_o = nxt_idx;

  zs_shift #(.W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (load_word),
    .shift_i(busy_q),
    .bit_o  (sh_bit),
    .last_o (last_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      token_q  <= 1'b0;
      kind_q   <= K_ID;
      cur_ch_q <= '0;
      ev_idx_q <= '0;
    end else begin
      token_q <= 1'b0;
      if (!busy_q) begin
        if (token_i) begin
          if (start_send) begin
            busy_q <= 1'b1;
            kind_q <= K_ID;
          end else begin
            token_q <= 1'b1;
          end
        end
      end else if (last_bit) begin
        if (step_ev) begin
          kind_q   <= K_EV;
          ev_idx_q <= nxt_idx;
        end else if (found) begin
          kind_q   <= K_HDR;
          cur_ch_q <= found_idx;
        end else begin
          busy_q  <= 1'b0;
          token_q <= 1'b1;
        end
      end
    end
  end

  assign dout_o    = busy_q & sh_bit;
  assign dout_en_o = busy_q;
  assign token_o   = token_q;

  p_token_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |=> !token_o);
  p_token_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |-> !dout_en_o);
  p_skip_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last_bit && !step_ev && found) |-> (cnt_found != '0));
  p_ascending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last_bit && !step_ev && found && kind_q != K_ID) |-> (found_idx > cur_ch_q));
  p_ev_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && kind_q == K_EV) |-> (CNT_W'(ev_idx_q) < cnt_cur));
  p_no_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_bit) |=> (busy_q && !token_o));
endmodule

// File: tb/zs_readout_ser_bench.sv
module zs_readout_ser_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   chip_id = 8'hE2;
  logic         arcid = 1'b0;
  logic         token_in = 1'b0;
  logic [255:0] hit_vec;
  logic [5:0]   ev_ch;
  logic [2:0]   ev_idx;
  logic [13:0]  ev_data;
  logic         dout, dout_en, token_out;

  logic [3:0]  cnt_m  [64];
  logic [11:0] bcid_m [64][8];
  logic [1:0]  disc_m [64][8];

  logic [15:0] exp_w [577];
  int          nexp;
  logic        got_b [9300];
  int          nbits;
  int          checks = 0, failures = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < 64; c++) hit_vec[c*4 +: 4] = cnt_m[c];
  end
  assign ev_data = {bcid_m[ev_ch][ev_idx], disc_m[ev_ch][ev_idx]};

  zs_readout_ser u_zs_readout_ser (
    .clk_i(clk), .rst_ni(rst_n), .chip_id_i(chip_id), .arcid_i(arcid),
    .token_i(token_in), .hit_cnt_i(hit_vec), .ev_ch_o(ev_ch), .ev_idx_o(ev_idx),
    .ev_data_i(ev_data), .dout_o(dout), .dout_en_o(dout_en), .token_o(token_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] seal(input logic [15:0] w);
    logic [15:0] r;
    r = w;
    r[0] = ^w[15:1];
    return r;
  endfunction

  task automatic fill(input int seed, input int mode);
    for (int c = 0; c < 64; c++) begin
      case (mode)
        0: cnt_m[c] = 4'd0;
        1: cnt_m[c] = (c == 20) ? 4'd3 : (c == 43) ? 4'd1 : (c == 63) ? 4'd2 : 4'd0;
        2: cnt_m[c] = 4'd8;
        default: cnt_m[c] = 4'((c * 7 + seed) % 9);
      endcase
      for (int i = 0; i < 8; i++) begin
        bcid_m[c][i] = 12'((c * 37 + i * 101 + seed * 13) & 12'hfff);
        disc_m[c][i] = 2'((c + i + seed) & 3);
      end
    end
  endtask

  task automatic build_exp();
    bit any = 0;
    nexp = 0;
    for (int c = 0; c < 64; c++) if (cnt_m[c] != 0) any = 1;
    if (!any && !arcid) return;
    exp_w[nexp++] = seal({chip_id, 8'h00});
    for (int c = 0; c < 64; c++) begin
      if (cnt_m[c] != 0) begin
        exp_w[nexp++] = seal({1'b1, 6'(c), cnt_m[c], 5'b0});
        for (int i = 0; i < int'(cnt_m[c]); i++)
          exp_w[nexp++] = seal({1'b0, bcid_m[c][i], disc_m[c][i], 1'b0});
      end
    end
  endtask

  // Pulse token, capture stream, compare against expected words.
  task automatic run(input string name, input bit mid_tok);
    bit done = 0, gap = 0, tok_ok = 0, prev_en = 0, wrong = 0, parity_bad = 0;
    int bad_w = -1;
    logic [15:0] w;
    build_exp();
    nbits = 0;
    @(negedge clk) token_in = 1'b1;
    @(negedge clk) token_in = 1'b0;
    for (int cyc = 0; cyc < 20000 && !done; cyc++) begin
      if (mid_tok) token_in = (cyc == 100);
      if (dout_en) begin
        if (token_out) wrong = 1;
        if (nbits > 0 && !prev_en) gap = 1;
        if (nbits < 9300) got_b[nbits] = dout;
        nbits++;
      end else if (token_out) begin
        done = 1;
        tok_ok = (nbits == 0) ? (cyc == 0) : prev_en;
      end else if (nbits > 0) begin
        gap = 1;
      end
      prev_en = dout_en;
      @(negedge clk);
    end
    token_in = 1'b0;
    check(done && tok_ok, {name, " R10 token right after stream"}, int'(tok_ok), 1);
    check(!token_out && !dout_en, {name, " R10 token single cycle"}, int'(token_out), 0);
    check(!wrong, {name, " R10 no token while driving"}, int'(wrong), 0);
    check(!gap, {name, " R3 contiguous drive"}, int'(gap), 0);
    check(nbits == nexp * 16, {name, " R3 bit count"}, nbits, nexp * 16);
    if (nbits == nexp * 16) begin
      for (int k = 0; k < nexp; k++) begin
        for (int b = 0; b < 16; b++) w[15-b] = got_b[k*16 + b];
        if (^w != 1'b0) parity_bad = 1;
        if (w != exp_w[k] && bad_w < 0) bad_w = k;
      end
      if (nexp > 0)
        check(got_b[0] == chip_id[7], {name, " R2 id word first MSB"}, int'(got_b[0]), int'(chip_id[7]));
      check(!parity_bad, {name, " R6 even parity"}, int'(parity_bad), 0);
      check(bad_w < 0, {name, " R4 R5 R7 word stream"}, bad_w, -1);
    end
  endtask

  task automatic t_reset();
    check(!dout_en && !dout && !token_out, "R1 reset outputs", {dout_en, dout, token_out}, 0);
  endtask

  task automatic t_sparse();
    arcid = 1'b0; chip_id = 8'hE2; fill(1, 1);
    run("sparse R4 R5 R7", 1'b0);
    check(nexp == 1 + 2 + 3 + 2 + 2, "sparse R7 expected size", nexp, 10);
  endtask

  task automatic t_full();
    arcid = 1'b1; chip_id = 8'h5A; fill(2, 2);
    run("full R5", 1'b0);
    check(nexp == 577, "full R5 577 words", nexp, 577);
  endtask

  task automatic t_mixed();
    arcid = 1'b0; chip_id = 8'h3C; fill(5, 3);
    run("mixed R7", 1'b0);
  endtask

  task automatic t_empty_off();
    arcid = 1'b0; fill(0, 0);
    run("empty R8", 1'b0);
    check(nbits == 0, "R8 nothing sent", nbits, 0);
  endtask

  task automatic t_empty_on();
    arcid = 1'b1; chip_id = 8'hA7; fill(0, 0);
    run("empty R9", 1'b0);
    check(nbits == 16, "R9 only id word", nbits, 16);
  endtask

  task automatic t_mid_token();
    arcid = 1'b0; chip_id = 8'h81; fill(3, 1);
    run("R11 mid token", 1'b1);
    repeat (20) begin
      @(negedge clk);
      check(!token_out && !dout_en, "R11 no second run", {token_out, dout_en}, 0);
    end
  endtask

  initial begin
    fill(0, 0);
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_sparse();
    t_full();
    t_mixed();
    t_empty_off();
    t_empty_on();
    t_mid_token();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule